// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous DRAM interface. It oversamples the row strobe, column strobe, write enable and output enable on a fast clock and sorts each memory cycle by the order in which the strobe edges arrive. It captures the row and column addresses and keeps the internal counter that supplies refresh rows. It also drives the enable that opens the data pins. The storage array is not part of the block. The block hands it one-cycle read, write and refresh strobes with the latched addresses.

The classification is reported on `cyc_type` and is updated as the edges arrive. A cycle that opens with only the row strobe is reported as a row-only refresh until a column strobe turns it into an access. The block is meant as a behavioural front end or as a synthesizable protocol checker. For that reason it also pulses `viol` on an edge order it cannot classify, on a row strobe held low too long in a single-access cycle, and on a precharge that is too short after self refresh.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: When the row strobe falls while the column strobe is already low, the cycle is a counter refresh (`cyc_type` 6). When the row strobe rises it pulses `rfsh_stb` with `rfsh_row` equal to the counter, and the counter then steps by one. The counter is 0 after reset.
- R2: When the row strobe falls with the column strobe high, the row on `addr` is captured and `cyc_type` becomes 5. If no column strobe falls before the row strobe rises, `rfsh_stb` pulses with `rfsh_row` equal to the captured row.
- R3: A column strobe fall while write enable is low is an early write: `cyc_type` 2, one `wr_stb` pulse, and `dq_oe` stays low for the whole cycle whatever output enable does.
- R4: A column strobe fall while write enable is high is a read: `cyc_type` 1, one `rd_stb` pulse, and the column is captured. From then on `dq_oe` follows output enable (active low).
- R5: A write enable fall during a read access with the column strobe low ends the read with a `wr_stb` pulse. It gives `cyc_type` 4 (read-modify-write) if read data was already driven, and `cyc_type` 3 (output-enable-controlled write) if it was not. `dq_oe` drops.
- R6: Read data stays enabled until both the row and the column strobe are high. The output is released by whichever of the two rises last.
- R7: If the row strobe rises and falls again while the column strobe stays low after an access, the new row-low period is reported as a hidden refresh (`cyc_type` 7). It refreshes from the counter as in R1, and `dq_oe` stays high throughout.
- R8: A counter refresh whose row strobe stays low for SELF_CYC samples becomes self refresh (`cyc_type` 8). After it ends, a row strobe fall that comes after fewer than SELF_PRE high samples pulses `viol`.
- R9: A counter refresh that starts with write enable low is a test-mode entry (`cyc_type` 9) and sets `test_mode`. A later plain counter refresh or a completed row-only refresh clears it.
- R10: `viol` pulses when the row and column strobes are first seen low in the same sample, or when a row strobe stays low for more than RAS_MAX samples in a cycle with at most one column access. A page cycle with two or more column accesses is exempt, and each of its accesses gives its own strobe and column.
- R11: After reset, `cyc_type` is 0 and `rd_stb`, `wr_stb`, `rfsh_stb`, `dq_oe`, `test_mode`, `viol` and `rfsh_row` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address pins |
| cyc_type | output | 4 | Current cycle classification code |
| row_addr | output | ROW_W | Captured row |
| col_addr | output | COL_W | Captured column |
| rd_stb | output | 1 | One-cycle read request to the array |
| wr_stb | output | 1 | One-cycle write request to the array |
| rfsh_stb | output | 1 | One-cycle refresh request |
| rfsh_row | output | ROW_W | Row refreshed by the last `rfsh_stb` |
| dq_oe | output | 1 | Data pin drive enable |
| test_mode | output | 1 | Test mode active |
| viol | output | 1 | One-cycle protocol violation pulse |

## Verification
The bench steps through strobe sequences that differ only in edge order. The column strobe falls before or after the row strobe, and write enable is low before the column fall, after it with data shown, or after it with data never shown. Telling these apart checks counter refresh against row-only refresh, and early write against read-modify-write against output-enable write. Endings with the row strobe rising first or the column strobe rising first tell the two release rules apart. A row-strobe bounce under a held column strobe separates hidden refresh from an ordinary counter refresh. Long row-low holds with one access, two accesses and a counter refresh separate the limit violation from its exemptions and from self refresh.

// File: rtl/strobe_dec_pkg.sv
// Shared cycle codes for the strobe decoder.
package strobe_dec_pkg;
    typedef enum logic [3:0] {
        CYC_NONE   = 4'd0,
        CYC_READ   = 4'd1,
        CYC_EWR    = 4'd2,
        CYC_OEWR   = 4'd3,
        CYC_RMW    = 4'd4,
        CYC_RONLY  = 4'd5,
        CYC_CBR    = 4'd6,
        CYC_HIDDEN = 4'd7,
        CYC_SELF   = 4'd8,
        CYC_TEST   = 4'd9
    } cyc_e;
endpackage

// File: rtl/strobe_edges.sv
// Registers the previous level of N active-low strobes and reports
// falling edges for all of them, rising edges for the low RISE_N bits.
// Assumes strobes are already synchronous to clk. Idle level is high.
module strobe_edges #(
    parameter int N      = 3,
    parameter int RISE_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      lvl,
    output logic [N-1:0]      fall,
    output logic [RISE_N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Hold last sampled level; reset to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fall[i] = prev_q[i] & ~lvl[i];
        if (i < RISE_N) begin : g_rise
            assign rise[i] = ~prev_q[i] & lvl[i];
        end
    end
endmodule

// File: rtl/lvl_timer.sv
// Counts consecutive samples for which run is high; clears when run is low.
// Saturates at all ones so long holds never wrap.
module lvl_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt
);
    // Saturating run-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfsh_counter.sv
// Internal refresh row pointer; steps once per inc pulse and wraps.
module rfsh_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] row
);
    // Advance the refresh pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end
endmodule

// File: rtl/strobe_cycle_decoder.sv
// Classifies DRAM cycles from the order of strobe edges seen on clk.
// Assumes the strobes are synchronous to clk and that clk is fast enough
// to separate every edge the protocol orders. Emits array strobes, drives
// the data-pin enable and keeps the refresh row counter.
module strobe_cycle_decoder
    import strobe_dec_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 10,
    parameter int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
    parameter int SELF_CYC = 10000,
    parameter int RAS_MAX  = 1000,
    parameter int SELF_PRE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cyc_type,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              rfsh_stb,
    output logic [ROW_W-1:0]  rfsh_row,
    output logic              dq_oe,
    output logic              test_mode,
    output logic              viol
);
    localparam int MAXV = (SELF_CYC > RAS_MAX) ?
                          ((SELF_CYC > SELF_PRE) ? SELF_CYC : SELF_PRE) :
                          ((RAS_MAX > SELF_PRE) ? RAS_MAX : SELF_PRE);
    localparam int CW = $clog2(MAXV + 2);

    logic [2:0]    fall;
    logic [1:0]    rise;
    logic          ras_fall, cas_fall, we_fall, ras_rise, cas_rise;
    logic [CW-1:0] lo_cnt, hi_cnt;
    logic [ROW_W-1:0] ctr_q;
    logic          ctr_inc;
    cyc_e          cyc_q;
    logic          act_q, cbr_q, acc_q, page_q, rd_q, shown_q;
    logic          dval_q, hold_q, self_q, exit_q;

    strobe_edges #(.N(3), .RISE_N(2)) u_edges (
        .clk(clk), .rst_n(rst_n), .lvl({we_n, cas_n, ras_n}),
        .fall(fall), .rise(rise)
    );
    lvl_timer #(.CW(CW)) u_lo (.clk(clk), .rst_n(rst_n), .run(~ras_n), .cnt(lo_cnt));
    lvl_timer #(.CW(CW)) u_hi (.clk(clk), .rst_n(rst_n), .run(ras_n),  .cnt(hi_cnt));
    rfsh_counter #(.W(ROW_W)) u_ctr (.clk(clk), .rst_n(rst_n), .inc(ctr_inc), .row(ctr_q));

    assign ras_fall = fall[0];
    assign cas_fall = fall[1];
    assign we_fall  = fall[2];
    assign ras_rise = rise[0];
    assign cas_rise = rise[1];
    assign ctr_inc  = ras_rise & act_q & cbr_q;
    assign cyc_type = cyc_q;
    assign dq_oe    = dval_q & ~oe_n;

    // Cycle classification, address capture, strobes and violations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= CYC_NONE;  row_addr <= '0; col_addr <= '0;
            rd_stb <= 1'b0; wr_stb <= 1'b0; rfsh_stb <= 1'b0; rfsh_row <= '0;
            test_mode <= 1'b0; viol <= 1'b0;
            act_q <= 1'b0; cbr_q <= 1'b0; acc_q <= 1'b0; page_q <= 1'b0;
            rd_q <= 1'b0; shown_q <= 1'b0; dval_q <= 1'b0; hold_q <= 1'b0;
            self_q <= 1'b0; exit_q <= 1'b0;
        end else begin
            rd_stb <= 1'b0; wr_stb <= 1'b0; rfsh_stb <= 1'b0; viol <= 1'b0;
            if (dval_q && !oe_n && !cas_n) shown_q <= 1'b1;
            if (cas_rise)          hold_q <= 1'b0;
            if (ras_n && cas_n)    dval_q <= 1'b0;
            if (ras_fall) begin
                act_q <= 1'b1; acc_q <= 1'b0; page_q <= 1'b0;
                exit_q <= 1'b0; hold_q <= 1'b0;
                if (exit_q && hi_cnt < CW'(SELF_PRE)) viol <= 1'b1;
                if (cas_fall) begin
                    viol <= 1'b1; cbr_q <= 1'b0; cyc_q <= CYC_NONE;
                end else if (!cas_n) begin
                    cbr_q <= 1'b1;
                    if (!we_n) begin
                        cyc_q <= CYC_TEST; test_mode <= 1'b1;
                    end else if (hold_q) begin
                        cyc_q <= CYC_HIDDEN;
                    end else begin
                        cyc_q <= CYC_CBR; test_mode <= 1'b0;
                    end
                end else begin
                    cbr_q <= 1'b0; row_addr <= addr[ROW_W-1:0]; cyc_q <= CYC_RONLY;
                end
            end else if (ras_rise && act_q) begin
                act_q <= 1'b0; cbr_q <= 1'b0;
                if (cbr_q) begin
                    rfsh_stb <= 1'b1; rfsh_row <= ctr_q;
                end else if (!acc_q && cyc_q == CYC_RONLY) begin
                    rfsh_stb <= 1'b1; rfsh_row <= row_addr; test_mode <= 1'b0;
                end
                if (!cas_n && acc_q) hold_q <= 1'b1;
                if (self_q) begin
                    self_q <= 1'b0; exit_q <= 1'b1;
                end
            end else if (act_q && !ras_n) begin
                if (cbr_q && !self_q && lo_cnt == CW'(SELF_CYC - 1)) begin
                    self_q <= 1'b1; cyc_q <= CYC_SELF;
                end
                if (!cbr_q && !page_q && lo_cnt == CW'(RAS_MAX)) viol <= 1'b1;
                if (!cbr_q && cas_fall) begin
                    col_addr <= addr[COL_W-1:0]; page_q <= acc_q; acc_q <= 1'b1;
                    if (!we_n) begin
                        cyc_q <= CYC_EWR; wr_stb <= 1'b1; dval_q <= 1'b0; rd_q <= 1'b0;
                    end else begin
                        cyc_q <= CYC_READ; rd_stb <= 1'b1; dval_q <= 1'b1;
                        rd_q <= 1'b1; shown_q <= 1'b0;
                    end
                end else if (!cbr_q && we_fall && !cas_n && rd_q) begin
                    cyc_q  <= (shown_q || (dval_q && !oe_n)) ? CYC_RMW : CYC_OEWR;
                    wr_stb <= 1'b1; rd_q <= 1'b0; dval_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/strobe_decoder_chk.sv
// Protocol properties for strobe_cycle_decoder, attached by bind.
module strobe_decoder_chk #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic [3:0]       cyc_type,
    input logic             wr_stb,
    input logic             rfsh_stb,
    input logic [ROW_W-1:0] rfsh_row,
    input logic [ROW_W-1:0] row_addr,
    input logic [ROW_W-1:0] ctr_q,
    input logic             test_mode
);
    // Counter refresh reports the pointer value just before it stepped.
    assert_ctr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_stb && (cyc_type == 4'd6 || cyc_type == 4'd7 ||
                      cyc_type == 4'd8 || cyc_type == 4'd9))
        |-> ctr_q == ROW_W'(rfsh_row + 1'b1));

    // Row-only refresh uses the captured row.
    assert_ronly_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_stb && cyc_type == 4'd5) |-> rfsh_row == row_addr);

    // Early write never opens the data pins right after its strobe.
    assert_ewr_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cyc_type == 4'd2) |=> !dq_oe);

    // Both strobes high releases the output.
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n) && $past(cas_n)) |-> !dq_oe);

    // Test mode is entered only by a counter refresh with write enable low.
    assert_test_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> $past(!we_n && !cas_n && !ras_n));
endmodule

bind strobe_cycle_decoder strobe_decoder_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dq_oe(dq_oe), .cyc_type(cyc_type), .wr_stb(wr_stb), .rfsh_stb(rfsh_stb),
    .rfsh_row(rfsh_row), .row_addr(row_addr), .ctr_q(ctr_q), .test_mode(test_mode)
);

// File: tb/sim_strobe_cycle_decoder.sv
module sim_strobe_cycle_decoder;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0] addr = '0;
    logic [3:0] cyc_type;
    logic [7:0] row_addr, col_addr, rfsh_row;
    logic rd_stb, wr_stb, rfsh_stb, dq_oe, test_mode, viol;
    int errs = 0, checks = 0;

    always #10 clk = ~clk;

    strobe_cycle_decoder #(.ROW_W(8), .COL_W(8), .SELF_CYC(40),
                           .RAS_MAX(24), .SELF_PRE(6)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type), .row_addr(row_addr),
        .col_addr(col_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .dq_oe(dq_oe),
        .test_mode(test_mode), .viol(viol));

    typedef struct packed {
        logic r, c, w, o; logic [7:0] a;
        logic [3:0] t; logic rd, wr, oe, rf, vl;
    } vec_t;

    localparam vec_t TBL [17] = '{
        '{1'b1,1'b1,1'b1,1'b1,8'h00, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,8'h12, 4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b1,8'h34, 4'd1, 1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b0,8'h34, 4'd1, 1'b0,1'b0,1'b1,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,1'b0,8'h34, 4'd1, 1'b0,1'b0,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,8'h00, 4'd1, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,8'h20, 4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,8'h05, 4'd2, 1'b0,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,8'h05, 4'd2, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,8'h00, 4'd2, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,8'h77, 4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,8'h00, 4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,8'h00, 4'd5, 1'b0,1'b0,1'b0,1'b1,1'b0},
        '{1'b1,1'b0,1'b1,1'b1,8'h00, 4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b1,8'h00, 4'd6, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,1'b1,8'h00, 4'd6, 1'b0,1'b0,1'b0,1'b1,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,8'h00, 4'd6, 1'b0,1'b0,1'b0,1'b0,1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one sample of strobes, then look just after the clock edge.
    task automatic tick(input logic r, c, w, o, input logic [7:0] a);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #3000000;
        errs++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic seen;
        int n;
        do_reset();
        #1;
        // R11 reset state
        chk("R11 type", cyc_type, 0);
        chk("R11 strobes", {rd_stb, wr_stb, rfsh_stb, dq_oe, test_mode, viol}, 0);
        chk("R11 rfsh_row", rfsh_row, 0);

        // Table walk: read, early write, row-only refresh, counter refresh
        for (int i = 0; i < 17; i++) begin
            tick(TBL[i].r, TBL[i].c, TBL[i].w, TBL[i].o, TBL[i].a);
            chk($sformatf("R4/R3/R2/R1 type step %0d", i), cyc_type, TBL[i].t);
            chk($sformatf("R4 rd_stb step %0d", i), rd_stb, TBL[i].rd);
            chk($sformatf("R3/R5 wr_stb step %0d", i), wr_stb, TBL[i].wr);
            chk($sformatf("R6 dq_oe step %0d", i), dq_oe, TBL[i].oe);
            chk($sformatf("R1/R2 rfsh_stb step %0d", i), rfsh_stb, TBL[i].rf);
            chk($sformatf("R10 viol step %0d", i), viol, TBL[i].vl);
            if (i == 4) begin
                chk("R4 row", row_addr, 8'h12);
                chk("R4 col", col_addr, 8'h34);
            end
            if (i == 12) chk("R2 refresh row", rfsh_row, 8'h77);
            if (i == 15) chk("R1 first counter row", rfsh_row, 0);
        end
        // R1 second counter refresh steps the pointer
        tick(1,0,1,1,0); tick(0,0,1,1,0); tick(1,0,1,1,0);
        chk("R1 rfsh_stb", rfsh_stb, 1);
        chk("R1 counter advanced", rfsh_row, 1);
        tick(1,1,1,1,0);

        // R5 read-modify-write: data shown before W falls
        tick(0,1,1,1,8'h10); tick(0,0,1,1,8'h22); tick(0,0,1,0,8'h22);
        chk("R5 data shown", dq_oe, 1);
        tick(0,0,1,1,8'h22); tick(0,0,0,1,8'h22);
        chk("R5 rmw type", cyc_type, 4);
        chk("R5 rmw wr_stb", wr_stb, 1);
        tick(0,0,0,0,8'h22);
        chk("R5 output off after write", dq_oe, 0);
        tick(1,1,1,1,0);
        // R5 output-enable write: data never shown
        tick(0,1,1,1,8'h11); tick(0,0,1,1,8'h23); tick(0,0,0,1,8'h23);
        chk("R5 oe-write type", cyc_type, 3);
        chk("R5 oe-write wr_stb", wr_stb, 1);
        tick(1,1,1,1,0);

        // R6 column strobe rises first: output held until row strobe rises
        tick(0,1,1,1,8'h01); tick(0,0,1,0,8'h02); tick(0,1,1,0,8'h02);
        chk("R6 held after CAS rise", dq_oe, 1);
        tick(1,1,1,0,0);
        chk("R6 released by RAS rise", dq_oe, 0);

        // R7 hidden refresh
        do_reset();
        tick(0,1,1,1,8'h40); tick(0,0,1,0,8'h41); tick(1,0,1,0,8'h41);
        tick(0,0,1,0,0);
        chk("R7 hidden type", cyc_type, 7);
        chk("R7 data valid", dq_oe, 1);
        tick(0,0,1,0,0); tick(1,0,1,0,0);
        chk("R7 refresh strobe", rfsh_stb, 1);
        chk("R7 counter row", rfsh_row, 0);
        chk("R7 data still valid", dq_oe, 1);
        tick(1,1,1,0,0);
        chk("R7 released", dq_oe, 0);

        // R8 self refresh and short precharge after it
        do_reset();
        seen = 1'b0;
        tick(1,0,1,1,0); tick(0,0,1,1,0);
        for (int k = 0; k < 45; k++) begin tick(0,0,1,1,0); seen |= viol; end
        chk("R8 self type", cyc_type, 8);
        chk("R8 no limit viol in refresh", seen, 0);
        tick(1,0,1,1,0); tick(1,1,1,1,0); tick(1,1,1,1,0);
        tick(0,1,1,1,8'h05);
        chk("R8 short precharge viol", viol, 1);
        tick(1,1,1,1,0);

        // R9 test-mode entry and exit
        do_reset();
        tick(1,0,1,1,0); tick(0,0,0,1,0);
        chk("R9 test type", cyc_type, 9);
        chk("R9 test set", test_mode, 1);
        tick(1,0,1,1,0); tick(1,1,1,1,0);
        chk("R9 test kept", test_mode, 1);
        tick(1,0,1,1,0); tick(0,0,1,1,0);
        chk("R9 test cleared", test_mode, 0);
        tick(1,0,1,1,0); tick(1,1,1,1,0);

        // R10 same-sample fall
        tick(0,0,1,1,0);
        chk("R10 same-sample viol", viol, 1);
        tick(1,1,1,1,0); tick(1,1,1,1,0);
        // R10 single-access overlong cycle
        seen = 1'b0;
        tick(0,1,1,1,8'h03); tick(0,0,1,1,8'h04);
        for (int k = 0; k < 30; k++) begin tick(0,0,1,1,0); seen |= viol; end
        chk("R10 overlong viol", seen, 1);
        tick(1,1,1,1,0); tick(1,1,1,1,0);
        // R10 page cycle exempt
        seen = 1'b0; n = 0;
        tick(0,1,1,1,8'h03); tick(0,0,1,1,8'h04); n += rd_stb;
        tick(0,1,1,1,8'h00); tick(0,0,1,1,8'h09); n += rd_stb;
        chk("R10 page column", col_addr, 8'h09);
        for (int k = 0; k < 30; k++) begin tick(0,0,1,1,0); seen |= viol; end
        chk("R10 page reads", n, 2);
        chk("R10 page no viol", seen, 0);
        tick(1,1,1,1,0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule